// File: doc/BRIEF.md
# Timeslot-24 Maintenance Framing Byte Inserter

This block sits in the transmit path of a T1 framer and places the maintenance framing byte into timeslot 24 of every outgoing frame. The byte has a fixed sync pattern with two alarm bits inside it: a yellow (Y) bit and a remote (R) bit. An 8-bit enable mask chooses, bit by bit, whether the generated value or the incoming system bit goes out. The caller can therefore insert only the sync pattern, only the alarm bits, or any mix of them. All other timeslots pass through unchanged. The Y and R values are supplied by surrounding logic; this block does not generate them.

Bytes move on a byte-clock enable. Every byte, in any timeslot, leaves exactly one accepted byte later through a single output register. Two flags travel with each output byte. One marks the timeslot-24 position. The other shows whether insertion was active for that byte. A small state machine records what kind of byte the output register holds, and both flags are decoded from that state.

The state machine has four states:

- `ST_IDLE`: after reset, before any byte has been accepted.
- `ST_THRU`: the output holds a byte from an ordinary timeslot.
- `ST_MERGE`: the output holds a timeslot-24 byte that was merged under the mask.
- `ST_BYPASS`: the output holds a timeslot-24 byte that went out with insertion globally disabled.

The transitions depend only on the accepted byte, never on the current state:

- Any accepted byte from an ordinary timeslot moves the machine to `ST_THRU`.
- An accepted timeslot-24 byte moves it to `ST_MERGE` when the global enable is high.
- An accepted timeslot-24 byte moves it to `ST_BYPASS` when the global enable is low.
- With no byte accepted, the machine stays in its current state.

Top module: `ts24_pattern_inserter`

## Requirements
- R1: While reset is held and after its release, until the first accepted byte, `dout`, `dout_ts24` and `dout_ins` are all 0.
- R2: A byte accepted with `ts24` low appears unchanged on `dout` one accepted byte later.
- R3: In an accepted timeslot-24 byte with `ins_en` high, every sync position whose mask bit is 1 carries its fixed value. The positions and values are bit 7 = 1, bit 6 = 0, bit 5 = 1, bit 4 = 1, bit 3 = 1 and bit 0 = 0, with bit 7 sent first.
- R4: In that case, with `mask[2]` = 1, `dout[2]` equals `y_bit` as sampled on the accepting edge.
- R5: In that case, with `mask[1]` = 1, `dout[1]` equals `r_bit` as sampled on the accepting edge.
- R6: In an accepted timeslot-24 byte, each bit whose mask bit is 0 carries the matching `din` bit.
- R7: When `ins_en` is low on a timeslot-24 byte, the mask is treated as all zeros and the byte passes unchanged.
- R8: While `byte_en` is low, `dout`, `dout_ts24` and `dout_ins` hold their values.
- R9: `dout_ts24` is 1 exactly when the byte on `dout` came from timeslot 24. `dout_ins` is 1 exactly when that byte was merged with `ins_en` high.
- R10: `y_bit` and `r_bit` only matter on the accepting edge of a timeslot-24 byte. Changing them during other bytes leaves the output unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_en | input | 1 | Byte-clock enable; a byte is accepted on each edge where it is high |
| ts24 | input | 1 | Marks the present byte as timeslot 24 |
| din | input | 8 | System byte for the present timeslot |
| y_bit | input | 1 | Yellow alarm value to place in bit 2 |
| r_bit | input | 1 | Remote alarm value to place in bit 1 |
| mask | input | 8 | Per-bit insert enable; 1 selects the generated bit |
| ins_en | input | 1 | Global insertion enable; 0 forces the mask to zero |
| dout | output | 8 | Merged output byte |
| dout_ts24 | output | 1 | Output byte came from timeslot 24 |
| dout_ins | output | 1 | Output byte was merged with insertion enabled |

## Verification
Every result is due on the first clock edge after the edge that accepts the byte, because exactly one register lies between input and output. Edges where `byte_en` is low add nothing but a hold. The bench drives inputs on the falling edge. A behavioural model updates on the same rising edge as the design. On each falling edge the bench compares all three outputs with the model before it drives the next inputs, so each output is compared half a clock after the edge that produced it. The stimulus is aimed at the boundaries: alarm inputs that flip in mid-frame, enable gaps placed just before timeslot 24, and masks that select only sync bits, only alarm bits, or none.

// File: rtl/ts24_pkg.sv
package ts24_pkg;
    localparam int BYTE_W = 8;
    localparam int Y_POS  = 2;
    localparam int R_POS  = 1;
    // fixed sync bits, alarm positions left at zero
    localparam logic [BYTE_W-1:0] SYNC_BITS = 8'b1011_1000;
    // positions that belong to the sync pattern
    localparam logic [BYTE_W-1:0] SYNC_POSN = ~((BYTE_W'(1) << Y_POS) | (BYTE_W'(1) << R_POS));

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_THRU   = 2'd1,
        ST_MERGE  = 2'd2,
        ST_BYPASS = 2'd3
    } ts24_state_e;
endpackage

// File: rtl/ts24_pattern_gen.sv
module ts24_pattern_gen
    import ts24_pkg::*;
(
    input  logic              y_bit,
    input  logic              r_bit,
    output logic [BYTE_W-1:0] pattern
);
    always_comb begin
        pattern        = SYNC_BITS & SYNC_POSN;
        pattern[Y_POS] = y_bit;
        pattern[R_POS] = r_bit;
    end
endmodule

// File: rtl/ts24_bit_merge.sv
module ts24_bit_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0] sys_byte,
    input  logic [W-1:0] gen_byte,
    input  logic [W-1:0] sel,
    output logic [W-1:0] merged
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign merged[i] = sel[i] ? gen_byte[i] : sys_byte[i];
    end
endmodule

// File: rtl/ts24_pattern_inserter.sv
module ts24_pattern_inserter
    import ts24_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_en,
    input  logic              ts24,
    input  logic [BYTE_W-1:0] din,
    input  logic              y_bit,
    input  logic              r_bit,
    input  logic [BYTE_W-1:0] mask,
    input  logic              ins_en,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_ts24,
    output logic              dout_ins
);
    ts24_state_e       st_q, st_d;
    logic [BYTE_W-1:0] gen_byte;
    logic [BYTE_W-1:0] eff_mask;
    logic [BYTE_W-1:0] merged;
    logic [BYTE_W-1:0] dout_q;

    ts24_pattern_gen u_gen (
        .y_bit   (y_bit),
        .r_bit   (r_bit),
        .pattern (gen_byte)
    );

    // global disable and non-TS24 bytes both zero the mask
    assign eff_mask = (ts24 && ins_en) ? mask : '0;

    ts24_bit_merge #(.W(BYTE_W)) u_merge (
        .sys_byte (din),
        .gen_byte (gen_byte),
        .sel      (eff_mask),
        .merged   (merged)
    );

    always_comb begin
        st_d = st_q;
        if (byte_en) begin
            unique case ({ts24, ins_en})
                2'b10:         st_d = ST_BYPASS;
                2'b11:         st_d = ST_MERGE;
                2'b00, 2'b01:  st_d = ST_THRU;
                default:       st_d = ST_THRU;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // output byte register
    always_ff @(posedge clk) begin
        if (!rst_n)       dout_q <= '0;
        else if (byte_en) dout_q <= merged;
    end

    // flags decoded from the state
    always_comb begin
        dout_ts24 = 1'b0;
        dout_ins  = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_THRU:   ;
            ST_MERGE:  begin dout_ts24 = 1'b1; dout_ins = 1'b1; end
            ST_BYPASS: dout_ts24 = 1'b1;
            default:   ;
        endcase
    end

    assign dout = dout_q;
endmodule

// File: rtl/ts24_pattern_inserter_chk.sv
module ts24_pattern_inserter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_en,
    input logic       ts24,
    input logic [7:0] din,
    input logic       y_bit,
    input logic       r_bit,
    input logic [7:0] mask,
    input logic       ins_en,
    input logic [7:0] dout,
    input logic       dout_ts24,
    input logic       dout_ins
);
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en && !ts24 |=> dout == $past(din));

    a_r3_sync_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en && ts24 && ins_en && mask[7] |=> dout[7] == 1'b1);

    a_r3_sync_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en && ts24 && ins_en && mask[0] |=> dout[0] == 1'b0);

    a_r4_y_bit: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en && ts24 && ins_en && mask[2] |=> dout[2] == $past(y_bit));

    a_r5_r_bit: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en && ts24 && ins_en && mask[1] |=> dout[1] == $past(r_bit));

    a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en && ts24 && !ins_en |=> dout == $past(din));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_en |=> $stable(dout) && $stable(dout_ts24) && $stable(dout_ins));

    a_r9_flags: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en |=> dout_ts24 == $past(ts24) && dout_ins == $past(ts24 && ins_en));
endmodule

bind ts24_pattern_inserter ts24_pattern_inserter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_en   (byte_en),
    .ts24      (ts24),
    .din       (din),
    .y_bit     (y_bit),
    .r_bit     (r_bit),
    .mask      (mask),
    .ins_en    (ins_en),
    .dout      (dout),
    .dout_ts24 (dout_ts24),
    .dout_ins  (dout_ins)
);

// File: tb/tb_ts24_pattern_inserter.sv
module tb_ts24_pattern_inserter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_en = 1'b0;
    logic       ts24 = 1'b0;
    logic [7:0] din = 8'h00;
    logic       y_bit = 1'b0;
    logic       r_bit = 1'b0;
    logic [7:0] mask = 8'h00;
    logic       ins_en = 1'b0;
    logic [7:0] dout;
    logic       dout_ts24, dout_ins;

    int total = 0;
    int bad = 0;
    string tag = "R1";
    logic [7:0] exp_dout = 8'h00;
    logic       exp_ts = 1'b0;
    logic       exp_ins = 1'b0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    ts24_pattern_inserter dut (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .ts24(ts24), .din(din),
        .y_bit(y_bit), .r_bit(r_bit), .mask(mask), .ins_en(ins_en),
        .dout(dout), .dout_ts24(dout_ts24), .dout_ins(dout_ins)
    );

    // behavioural reference: one accepted byte of delay
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_dout <= 8'h00; exp_ts <= 1'b0; exp_ins <= 1'b0;
        end else if (byte_en) begin
            if (ts24 && ins_en) begin
                int gen;
                gen = 'hB8 + (y_bit ? 4 : 0) + (r_bit ? 2 : 0);
                exp_dout <= 8'((gen & mask) | (din & ~mask));
            end else begin
                exp_dout <= din;
            end
            exp_ts  <= ts24;
            exp_ins <= ts24 && ins_en;
        end
    end

    task automatic check_now();
        total++;
        if (dout !== exp_dout || dout_ts24 !== exp_ts || dout_ins !== exp_ins) begin
            bad++;
            $display("FAIL %s: got dout=%h ts=%b ins=%b expected dout=%h ts=%b ins=%b",
                     tag, dout, dout_ts24, dout_ins, exp_dout, exp_ts, exp_ins);
        end
    endtask

    // compare on the falling edge, then drive the next inputs
    task automatic step(input logic be, input logic t, input logic [7:0] d,
                        input logic y, input logic r, input logic [7:0] m,
                        input logic en, input string req);
        @(negedge clk);
        check_now();
        tag = req;
        byte_en = be; ts24 = t; din = d; y_bit = y; r_bit = r; mask = m; ins_en = en;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        logic [7:0] masks [6];
        string      reqs  [6];
        lcg = 32'h1234_5678;
        masks[0] = 8'hFF; reqs[0] = "R3";   // whole byte
        masks[1] = 8'h04; reqs[1] = "R4";   // Y only
        masks[2] = 8'h02; reqs[2] = "R5";   // R only
        masks[3] = 8'h00; reqs[3] = "R6";   // none
        masks[4] = 8'hA5; reqs[4] = "R6";   // mixed
        masks[5] = 8'hFF; reqs[5] = "R7";   // global disable
        din = 8'h5A; byte_en = 1'b1; ts24 = 1'b1; mask = 8'hFF; ins_en = 1'b1;
        repeat (3) begin @(negedge clk); tag = "R1"; check_now(); end
        rst_n = 1'b1;
        byte_en = 1'b0;
        @(negedge clk); tag = "R1"; check_now();   // R1 after release
        for (int f = 0; f < 12; f++) begin
            for (int s = 1; s <= 24; s++) begin
                logic be, y, r, en;
                logic [7:0] m;
                string rq;
                lcg = lcg * 32'd1103515245 + 32'd12345;
                be  = !(s % 7 == 0 || s == 23);                  // R8 gaps, one just before TS24
                y   = lcg[20] ^ (s[0]);                          // R10 toggles mid-frame
                r   = lcg[21];
                m   = masks[f % 6];
                en  = (f % 6 != 5);
                rq  = (s == 24) ? reqs[f % 6] : (be ? "R2" : "R8");
                if (s == 24 && f >= 6) rq = "R9";
                if (s == 12) rq = "R10";
                step(be, s == 24, lcg[15:8], y, r, m, en, rq);
                if (s == 24 && f == 6)
                    step(1'b0, 1'b0, 8'h00, ~y, ~r, 8'h00, 1'b0, "R8");
            end
        end
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, "R2");
        @(negedge clk); check_now();
        $display("  test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end
endmodule